// File: doc/BRIEF.md
# Fractional-Rate VGA Raster Generator with 5:6:5 Pixel Streaming

This block derives a VGA raster from a system clock that is much faster than the pixel rate and is not an integer multiple of it. A phase accumulator adds a programmable frequency word on every clock. Each carry out of the accumulator is one pixel step. The horizontal and vertical position counters move only on those steps. As a result, the pixel rate can be any fraction of the clock, and no divider or second clock domain is needed.

Each line starts with a front porch, then the horizontal sync pulse, then a back porch, and ends with the active pixels. Each frame starts with a block of blank lines, then the active lines, then a second block of blank lines, and ends with the vertical sync lines. During active pixels the block reads 16-bit 5:6:5 words from a linear frame buffer, one word per pixel step. The buffer has a one-clock registered read. The read address wraps at the image size. Each channel is widened to 8 bits and scaled by one shared intensity value. Sync flags pass through the same pipeline registers as the colour, so both sync outputs stay aligned to the pixels. A configuration input selects the sync polarity.

Top module: `vga_nco_streamer`

## Requirements
- R1: The pixel phase is kept modulo 2^31. Each clock adds `freq_word` to it, and a pixel step happens when the sum reaches 2^31 (2^31 or more gives a step every clock, 2^30 every second clock, 0 freezes the raster).
- R2: Each line counts, in pixel steps, H_FRONT porch pixels, then H_SYNC sync pixels, then H_BACK porch pixels, then H_ACTIVE active pixels.
- R3: Each frame counts V_TOP blank lines, then V_ACTIVE active lines, then V_BOTTOM blank lines, then V_SYNC sync lines. VSYNC is active from the first step of the first sync line to the end of the last sync line.
- R4: `fb_addr` is a word address. It is 0 after reset and rises by one on each active-pixel step. After IMG_WORDS-1 it wraps to 0.
- R5: `fb_data` is taken one clock after the address that produced it. The colour outputs show a pixel position two clocks after the position was reached.
- R6: Red is `fb_data[15:11]`, green is `fb_data[10:5]` and blue is `fb_data[4:0]`. Each is widened to 8 bits by repeating its top bits below it.
- R7: Each widened channel is multiplied by `intensity` and divided by 128, with the result truncated. Values above 128 act as 128, and 0 gives black.
- R8: The colour outputs are zero for every position outside the active area.
- R9: HSYNC and VSYNC pass through the same two-clock delay as the colour.
- R10: When `sync_act_high` is 0 both syncs are active-low; when it is 1 they are active-high. The selection acts on the outputs without delay.
- R11: While `rst_n` is low the colour is zero, both syncs are inactive and `fb_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_word | input | ACC_W | Phase increment per clock |
| intensity | input | GAIN_W | Common channel gain, 128 = unity |
| sync_act_high | input | 1 | Sync polarity select |
| fb_addr | output | AW | Frame buffer word address |
| fb_data | input | 16 | 5:6:5 word read one clock after its address |
| red | output | 8 | Red channel |
| green | output | 8 | Green channel |
| blue | output | 8 | Blue channel |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |

## Verification
The hardest case to reach is a fractional step rate. With such a rate, step spacing alternates between different clock counts, so porch and active edges fall on clocks that vary from line to line. The bench uses reduced line and frame sizes so that several whole frames run in a few hundred clocks. It switches the frequency word between every-clock, every-second-clock and three-eighths rates while a clock-accurate reference model runs alongside. It then sets the word to zero and confirms that the raster holds still. The memory pattern places all-ones, all-zeros and single-channel words at the first addresses, so channel widening and wrap-around are seen on full-scale values.

// File: rtl/vga_nco_pkg.sv
`timescale 1ns/1ps
package vga_nco_pkg;

   localparam int PIX_W  = 16;
   localparam int CH_W   = 8;
   localparam int NUM_CH = 3;

   typedef struct packed {
      logic vis;
      logic hs;
      logic vs;
   } raster_flags_t;

   // channel 0 red, 1 green, 2 blue
   function automatic int chan_width(input int c);
      return (c == 1) ? 6 : 5;
   endfunction

   function automatic int chan_lsb(input int c);
      return (c == 0) ? 11 : ((c == 1) ? 5 : 0);
   endfunction

endpackage

// File: rtl/vga_phase_nco.sv
`timescale 1ns/1ps
module vga_phase_nco #(
   parameter int ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] freq_word,
   output logic             step
);

   localparam int PH_W = ACC_W - 1;

   logic [PH_W-1:0] phase;
   logic [ACC_W:0]  sum;

   assign sum  = (ACC_W+1)'(phase) + (ACC_W+1)'(freq_word);
   assign step = |sum[ACC_W:ACC_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= '0;
      else        phase <= sum[PH_W-1:0];
   end

endmodule

// File: rtl/vga_raster_timer.sv
`timescale 1ns/1ps
module vga_raster_timer
   import vga_nco_pkg::*;
#(
   parameter int H_FRONT  = 16,
   parameter int H_SYNC   = 96,
   parameter int H_BACK   = 48,
   parameter int H_ACTIVE = 640,
   parameter int V_TOP    = 90,
   parameter int V_ACTIVE = 350,
   parameter int V_BOTTOM = 83,
   parameter int V_SYNC   = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   output raster_flags_t flags
);

   localparam int H_TOTAL = H_FRONT + H_SYNC + H_BACK + H_ACTIVE;
   localparam int V_TOTAL = V_TOP + V_ACTIVE + V_BOTTOM + V_SYNC;
   localparam int HW = $clog2(H_TOTAL);
   localparam int VW = $clog2(V_TOTAL);

   localparam logic [HW-1:0] H_SYNC_BEG = HW'(H_FRONT);
   localparam logic [HW-1:0] H_SYNC_END = HW'(H_FRONT + H_SYNC);
   localparam logic [HW-1:0] H_VIS_BEG  = HW'(H_FRONT + H_SYNC + H_BACK);
   localparam logic [HW-1:0] H_LAST     = HW'(H_TOTAL - 1);
   localparam logic [VW-1:0] V_VIS_BEG  = VW'(V_TOP);
   localparam logic [VW-1:0] V_VIS_END  = VW'(V_TOP + V_ACTIVE);
   localparam logic [VW-1:0] V_SYNC_BEG = VW'(V_TOTAL - V_SYNC);
   localparam logic [VW-1:0] V_LAST     = VW'(V_TOTAL - 1);

   logic [HW-1:0] hpos;
   logic [VW-1:0] vpos;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hpos <= '0;
         vpos <= '0;
      end else if (step) begin
         if (hpos == H_LAST) begin
            hpos <= '0;
            vpos <= (vpos == V_LAST) ? '0 : vpos + 1'b1;
         end else begin
            hpos <= hpos + 1'b1;
         end
      end
   end

   always_comb begin
      flags.hs  = (hpos >= H_SYNC_BEG) && (hpos < H_SYNC_END);
      flags.vs  = (vpos >= V_SYNC_BEG);
      flags.vis = (hpos >= H_VIS_BEG) && (vpos >= V_VIS_BEG) && (vpos < V_VIS_END);
   end

endmodule

// File: rtl/vga_pixel_fetch.sv
`timescale 1ns/1ps
module vga_pixel_fetch #(
   parameter int IMG_WORDS = 224000,
   parameter int AW        = $clog2(IMG_WORDS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          vis,
   output logic [AW-1:0] addr
);

   localparam logic [AW-1:0] LAST = AW'(IMG_WORDS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           addr <= '0;
      else if (step && vis) addr <= (addr == LAST) ? '0 : addr + 1'b1;
   end

endmodule

// File: rtl/vga_color_stage.sv
`timescale 1ns/1ps
module vga_color_stage
   import vga_nco_pkg::*;
#(
   parameter int GAIN_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  raster_flags_t     flags,
   input  logic [PIX_W-1:0]  pix,
   input  logic [GAIN_W-1:0] gain,
   input  logic              act_high,
   output logic [CH_W-1:0]   red,
   output logic [CH_W-1:0]   green,
   output logic [CH_W-1:0]   blue,
   output logic              hsync,
   output logic              vsync
);

   localparam logic [GAIN_W-1:0] FULL = GAIN_W'(1) << (GAIN_W - 1);
   localparam int PW = CH_W + GAIN_W;

   raster_flags_t                  flags_d;
   logic [GAIN_W-1:0]              gain_eff;
   logic [NUM_CH-1:0][CH_W-1:0]    scaled;
   logic [NUM_CH-1:0][CH_W-1:0]    rgb_q;
   logic                           hs_q;
   logic                           vs_q;

   assign gain_eff = (gain > FULL) ? FULL : gain;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int CW  = chan_width(c);
      localparam int LSB = chan_lsb(c);
      logic [CW-1:0]   raw;
      logic [CH_W-1:0] wide;
      assign raw       = pix[LSB +: CW];
      assign wide      = {raw, raw[CW-1 -: CH_W-CW]};
      assign scaled[c] = CH_W'((PW'(wide) * PW'(gain_eff)) >> (GAIN_W - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_d <= '0;
         rgb_q   <= '0;
         hs_q    <= 1'b0;
         vs_q    <= 1'b0;
      end else begin
         flags_d <= flags;
         rgb_q   <= flags_d.vis ? scaled : '0;
         hs_q    <= flags_d.hs;
         vs_q    <= flags_d.vs;
      end
   end

   assign red   = rgb_q[0];
   assign green = rgb_q[1];
   assign blue  = rgb_q[2];
   assign hsync = act_high ? hs_q : ~hs_q;
   assign vsync = act_high ? vs_q : ~vs_q;

endmodule

// File: rtl/vga_nco_streamer.sv
`timescale 1ns/1ps
module vga_nco_streamer
   import vga_nco_pkg::*;
#(
   parameter int ACC_W     = 32,
   parameter int GAIN_W    = 8,
   parameter int H_FRONT   = 16,
   parameter int H_SYNC    = 96,
   parameter int H_BACK    = 48,
   parameter int H_ACTIVE  = 640,
   parameter int V_TOP     = 90,
   parameter int V_ACTIVE  = 350,
   parameter int V_BOTTOM  = 83,
   parameter int V_SYNC    = 2,
   parameter int IMG_WORDS = H_ACTIVE * V_ACTIVE,
   parameter int AW        = $clog2(IMG_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ACC_W-1:0]  freq_word,
   input  logic [GAIN_W-1:0] intensity,
   input  logic              sync_act_high,
   output logic [AW-1:0]     fb_addr,
   input  logic [15:0]       fb_data,
   output logic [7:0]        red,
   output logic [7:0]        green,
   output logic [7:0]        blue,
   output logic              hsync,
   output logic              vsync
);

   if (H_FRONT < 1 || H_SYNC < 1 || H_BACK < 1 || H_ACTIVE < 1) begin : g_bad_line
      $error("line segments must each be at least one pixel");
   end
   if (V_TOP < 1 || V_ACTIVE < 1 || V_BOTTOM < 1 || V_SYNC < 1) begin : g_bad_frame
      $error("frame segments must each be at least one line");
   end
   if (IMG_WORDS < 2 || AW < $clog2(IMG_WORDS)) begin : g_bad_img
      $error("image size or address width out of range");
   end
   if (ACC_W < 2 || GAIN_W < 2 || GAIN_W > 16) begin : g_bad_width
      $error("accumulator or gain width out of range");
   end

   logic          step;
   raster_flags_t flags;

   vga_phase_nco #(.ACC_W(ACC_W)) i_nco (
      .clk       (clk),
      .rst_n     (rst_n),
      .freq_word (freq_word),
      .step      (step)
   );

   vga_raster_timer #(
      .H_FRONT (H_FRONT), .H_SYNC (H_SYNC), .H_BACK (H_BACK), .H_ACTIVE (H_ACTIVE),
      .V_TOP   (V_TOP),   .V_ACTIVE (V_ACTIVE), .V_BOTTOM (V_BOTTOM), .V_SYNC (V_SYNC)
   ) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .flags (flags)
   );

   vga_pixel_fetch #(.IMG_WORDS(IMG_WORDS), .AW(AW)) i_fetch (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (step),
      .vis   (flags.vis),
      .addr  (fb_addr)
   );

   vga_color_stage #(.GAIN_W(GAIN_W)) i_color (
      .clk      (clk),
      .rst_n    (rst_n),
      .flags    (flags),
      .pix      (fb_data),
      .gain     (intensity),
      .act_high (sync_act_high),
      .red      (red),
      .green    (green),
      .blue     (blue),
      .hsync    (hsync),
      .vsync    (vsync)
   );

endmodule

// File: rtl/vga_nco_streamer_chk.sv
`timescale 1ns/1ps
module vga_nco_streamer_chk #(
   parameter int ACC_W  = 32,
   parameter int GAIN_W = 8,
   parameter int AW     = 18
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ACC_W-1:0]  freq_word,
   input logic [GAIN_W-1:0] intensity,
   input logic              sync_act_high,
   input logic [AW-1:0]     fb_addr,
   input logic [7:0]        red,
   input logic [7:0]        green,
   input logic [7:0]        blue,
   input logic              hsync,
   input logic              vsync
);

   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fb_addr != $past(fb_addr)) |-> (fb_addr == $past(fb_addr) + 1'b1 || fb_addr == '0));

   assert_freeze_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (freq_word == '0) |=> (fb_addr == $past(fb_addr)));

   assert_hsync_black_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (hsync == sync_act_high) |-> (red == 8'd0 && green == 8'd0 && blue == 8'd0));

   assert_vsync_black_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (vsync == sync_act_high) |-> (red == 8'd0 && green == 8'd0 && blue == 8'd0));

   assert_gain_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (intensity == '0) |=> (red == 8'd0 && green == 8'd0 && blue == 8'd0));

endmodule

bind vga_nco_streamer vga_nco_streamer_chk #(
   .ACC_W (ACC_W), .GAIN_W (GAIN_W), .AW (AW)
) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .freq_word     (freq_word),
   .intensity     (intensity),
   .sync_act_high (sync_act_high),
   .fb_addr       (fb_addr),
   .red           (red),
   .green         (green),
   .blue          (blue),
   .hsync         (hsync),
   .vsync         (vsync)
);

// File: tb/test_vga_nco_streamer.sv
`timescale 1ns/1ps
module test_vga_nco_streamer;

   localparam int HF = 2, HS = 3, HB = 2, HA = 8;
   localparam int VT = 2, VA = 4, VB = 2, VS = 2;
   localparam int HT = HF + HS + HB + HA;
   localparam int VTT = VT + VA + VB + VS;
   localparam int IMG = HA * VA;
   localparam int AW = $clog2(IMG);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [31:0]   freq_word = 32'h8000_0000;
   logic [7:0]    intensity = 8'd128;
   logic          sync_act_high = 1'b0;
   logic [AW-1:0] fb_addr;
   logic [15:0]   fb_data = 16'h0;
   logic [7:0]    red, green, blue;
   logic          hsync, vsync;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   vga_nco_streamer #(
      .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB), .H_ACTIVE(HA),
      .V_TOP(VT), .V_ACTIVE(VA), .V_BOTTOM(VB), .V_SYNC(VS)
   ) i_vga_nco_streamer (
      .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .intensity(intensity),
      .sync_act_high(sync_act_high), .fb_addr(fb_addr), .fb_data(fb_data),
      .red(red), .green(green), .blue(blue), .hsync(hsync), .vsync(vsync)
   );

   function automatic logic [15:0] memf(input int a);
      case (a)
         0: return 16'hFFFF;
         1: return 16'h0000;
         2: return 16'hF800;
         3: return 16'h07E0;
         4: return 16'h001F;
         default: return 16'((a * 40503) ^ 16'hA5C3);
      endcase
   endfunction

   always @(posedge clk) fb_data <= memf(int'(fb_addr));

   // reference model built from the requirements
   typedef struct { int r, g, b; bit hs, vs; int addr; } exp_t;
   exp_t q[$];

   longint m_ph = 0;
   int m_h = 0, m_v = 0, m_addr = 0;
   bit m_vis1 = 0, m_hs1 = 0, m_vs1 = 0;
   logic [15:0] m_fbd = 16'h0;

   function automatic int scale(input int c8, input int g);
      int ge = (g > 128) ? 128 : g;
      return (c8 * ge) >> 7;
   endfunction

   always @(posedge clk) begin
      exp_t e;
      bit vis_now, stb;
      longint s;
      if (!rst_n) begin
         m_ph = 0; m_h = 0; m_v = 0; m_addr = 0;
         m_vis1 = 0; m_hs1 = 0; m_vs1 = 0;
         e = '{0, 0, 0, 0, 0, 0};
      end else begin
         logic [4:0] r5, b5;
         logic [5:0] g6;
         r5 = m_fbd[15:11]; g6 = m_fbd[10:5]; b5 = m_fbd[4:0];
         e.r = m_vis1 ? scale(int'({r5, r5[4:2]}), int'(intensity)) : 0;
         e.g = m_vis1 ? scale(int'({g6, g6[5:4]}), int'(intensity)) : 0;
         e.b = m_vis1 ? scale(int'({b5, b5[4:2]}), int'(intensity)) : 0;
         e.hs = m_hs1;
         e.vs = m_vs1;
         vis_now = (m_h >= HF + HS + HB) && (m_v >= VT) && (m_v < VT + VA);
         m_fbd  = memf(m_addr);
         m_vis1 = vis_now;
         m_hs1  = (m_h >= HF) && (m_h < HF + HS);
         m_vs1  = (m_v >= VTT - VS);
         s = m_ph + longint'(freq_word);
         stb = (s >= 64'h8000_0000);
         m_ph = s % 64'h8000_0000;
         if (stb) begin
            if (vis_now) m_addr = (m_addr == IMG - 1) ? 0 : m_addr + 1;
            if (m_h == HT - 1) begin
               m_h = 0;
               m_v = (m_v == VTT - 1) ? 0 : m_v + 1;
            end else m_h = m_h + 1;
         end
         e.addr = m_addr;
      end
      q.push_back(e);
   end

   task automatic check(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (q.size() > 0) begin
         exp_t e;
         logic exp_hs, exp_vs;
         e = q.pop_front();
         exp_hs = e.hs ? sync_act_high : ~sync_act_high;
         exp_vs = e.vs ? sync_act_high : ~sync_act_high;
         check(red == e.r, "R5 R6 R7 R8 red", int'(red), e.r);
         check(green == e.g, "R5 R6 R7 R8 green", int'(green), e.g);
         check(blue == e.b, "R5 R6 R7 R8 blue", int'(blue), e.b);
         check(hsync === exp_hs, "R2 R9 R10 hsync", int'(hsync), int'(exp_hs));
         check(vsync === exp_vs, "R3 R9 R10 vsync", int'(vsync), int'(exp_vs));
         check(int'(fb_addr) == e.addr, "R1 R4 fb_addr", int'(fb_addr), e.addr);
      end
   end

   bit seen_wrap = 0;
   logic [AW-1:0] prev_addr = '0;
   always @(negedge clk) begin
      if (rst_n && prev_addr == AW'(IMG - 1) && fb_addr == '0) seen_wrap = 1;
      prev_addr = fb_addr;
   end

   function automatic bit active(input bit use_v);
      return use_v ? (vsync === sync_act_high) : (hsync === sync_act_high);
   endfunction

   task automatic measure(input bit use_v, output int n);
      n = 0;
      @(negedge clk);
      while (active(use_v)) @(negedge clk);
      while (!active(use_v)) @(negedge clk);
      while (active(use_v)) begin n++; @(negedge clk); end
   endtask

   task automatic drive_at_edge();
      @(posedge clk); #2;
   endtask

   initial begin
      #(20 * 100000);
      n_chk++; n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      int n;
      logic [AW-1:0] a0;
      logic h0;
      int nz;
      repeat (4) @(negedge clk);
      // R11 reset state, active-low syncs idle high
      check(red == 0 && green == 0 && blue == 0, "R11 reset colour", int'(red | green | blue), 0);
      check(hsync == 1'b1 && vsync == 1'b1, "R11 R10 reset syncs", int'({hsync, vsync}), 3);
      check(fb_addr == '0, "R11 R4 reset address", int'(fb_addr), 0);
      drive_at_edge();
      rst_n = 1'b1;

      // every-clock stepping
      measure(1'b0, n);
      check(n == HS, "R2 hsync width at full rate", n, HS);
      measure(1'b1, n);
      check(n == VS * HT, "R3 vsync width at full rate", n, VS * HT);
      repeat (2 * HT * VTT) @(negedge clk);
      check(seen_wrap, "R4 address wrap seen", int'(seen_wrap), 1);

      // half rate, active-high syncs, half gain
      drive_at_edge();
      freq_word = 32'h4000_0000; intensity = 8'd64; sync_act_high = 1'b1;
      measure(1'b0, n);
      measure(1'b0, n);
      check(n == 2 * HS, "R1 R10 hsync width at half rate", n, 2 * HS);
      repeat (2 * 2 * HT * VTT) @(negedge clk);

      // fractional 3/8 rate, gain above full scale
      drive_at_edge();
      freq_word = 32'h3000_0000; intensity = 8'd200; sync_act_high = 1'b0;
      repeat (3 * HT * VTT) @(negedge clk);

      // zero gain gives black
      drive_at_edge();
      freq_word = 32'h8000_0000; intensity = 8'd0;
      repeat (2) @(negedge clk);
      nz = 0;
      for (int i = 0; i < HT * VTT; i++) begin
         @(negedge clk);
         if (red != 0 || green != 0 || blue != 0) nz++;
      end
      check(nz == 0, "R7 zero intensity black", nz, 0);

      // zero word freezes the raster
      drive_at_edge();
      freq_word = 32'h0; intensity = 8'd128;
      repeat (3) @(negedge clk);
      a0 = fb_addr; h0 = hsync;
      repeat (30) @(negedge clk);
      check(fb_addr == a0, "R1 frozen address", int'(fb_addr), int'(a0));
      check(hsync == h0, "R1 frozen hsync", int'(hsync), int'(h0));

      // polarity acts without delay
      drive_at_edge();
      sync_act_high = ~sync_act_high;
      #1;
      check(hsync == ~h0, "R10 polarity flip", int'(hsync), int'(~h0));
      repeat (4) @(negedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule